// File: doc/BRIEF.md
# Selectable Pin Interrupt Engine

The block turns a bank of input pins into a small set of interrupt request lines. Each channel has its own select register that names one pin of the bank. The selected pin passes through a synchroniser into an edge detector. A per-channel mode bit makes the channel either edge-sensitive or level-sensitive, and the result is one request line per channel.

Two enable registers have a meaning that depends on the channel's mode. On an edge channel they enable rising and falling edges. On a level channel the first one is a plain enable and the second one selects the active level. Software changes both enable registers only through separate set-only and clear-only write addresses. Captured edges can be cleared or forced through their own addresses. Writing the status register drops the pending requests of edge channels.

Access is a simple synchronous bus: a write strobe with address and data is taken on the rising clock edge, and the read data is a combinational decode of the address. All per-channel registers are one bit per channel (bit k is channel k) and read back in the low bits. Write-only addresses read as zero.

Top module: `pin_irq_engine`

## Requirements
- R1: After the asynchronous reset, every readable register reads 0 and `irq_o` is 0. Every address 0x00 to 0x13 reads 0.
- R2: The select register of channel k is at address k (0..7) and holds a 5-bit pin index. It reads back in bits 4:0. The channel then follows pin `pins_i[index]`, and several channels may name the same pin.
- R3: A selected pin is sampled by two flops in series. A level change on the pin becomes visible in a level-channel request after 2 rising clock edges. A captured edge becomes visible in the edge registers after 3 rising clock edges.
- R4: The rising-edge register (read at 0x0F) captures a 0-to-1 transition of the synchronised pin. The falling-edge register (read at 0x10) captures a 1-to-0 transition. Capture happens in every channel, whatever its mode or enables.
- R5: A write to 0x0F or 0x10 clears the captured bits that are written as 1 and leaves the bits written as 0 unchanged. A write to 0x11 or 0x12 sets the rising or falling captured bits that are written as 1.
- R6: When an edge arrives in the same cycle as a clear write to its bit, the edge stays captured.
- R7: Enable A reads at 0x09 and enable B reads at 0x0C. A write to 0x0A or 0x0D sets the bits written as 1. A write to 0x0B or 0x0E clears the bits written as 1. The set and clear addresses read as 0.
- R8: An edge channel (mode bit 0) requests while (rising captured AND enable A) OR (falling captured AND enable B).
- R9: A level channel (mode bit 1) requests while enable A is 1 and the synchronised pin equals enable B. Enable B = 1 means active-high and enable B = 0 means active-low.
- R10: The status address 0x13 reads `irq_o`. Writing it clears both captured edges of every edge channel whose bit is written as 1. The write has no effect on level channels.
- R11: The mode register at 0x08 is read/write, with 1 meaning level-sensitive and 0 meaning edge-sensitive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Asynchronous input pin bank |
| we_i | input | 1 | Write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` |
| irq_o | output | NUM_CH | One request line per channel |

## Verification
The bench sweeps every channel across every pin index, including several channels that name the same pin. A broken select decode or a broken capture mask would light up the wrong bits or miss the shared ones. It samples one edge early as well as on time, so an extra or a missing synchroniser stage shows as the wrong latency. A clear write is driven into the very cycle of a new edge; a design that lets the clear win would lose that edge. The enable pairs and pin patterns are swept exhaustively in both modes, which exposes a swapped meaning of the polarity bit or a status write that wrongly touches level channels.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_SEL0     = 5'h00;
  localparam logic [ADDR_W-1:0] A_MODE     = 5'h08;
  localparam logic [ADDR_W-1:0] A_ENA      = 5'h09;
  localparam logic [ADDR_W-1:0] A_ENA_SET  = 5'h0A;
  localparam logic [ADDR_W-1:0] A_ENA_CLR  = 5'h0B;
  localparam logic [ADDR_W-1:0] A_ENB      = 5'h0C;
  localparam logic [ADDR_W-1:0] A_ENB_SET  = 5'h0D;
  localparam logic [ADDR_W-1:0] A_ENB_CLR  = 5'h0E;
  localparam logic [ADDR_W-1:0] A_RISE     = 5'h0F;
  localparam logic [ADDR_W-1:0] A_FALL     = 5'h10;
  localparam logic [ADDR_W-1:0] A_RISE_SET = 5'h11;
  localparam logic [ADDR_W-1:0] A_FALL_SET = 5'h12;
  localparam logic [ADDR_W-1:0] A_STAT     = 5'h13;
endpackage

// File: rtl/pirq_channel.sv
module pirq_channel #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned SEL_W    = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                lvl_o,
  output logic                rise_o,
  output logic                fall_o
);
  logic pin_sel;
  logic meta_q, sync_q, dly_q;

  // mux ahead of the synchroniser: three flops per channel, not per pin
  always_comb begin
    pin_sel = 1'b0;
    if (32'(sel_i) < NUM_PINS) pin_sel = pins_i[sel_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      dly_q  <= 1'b0;
    end else begin
      meta_q <= pin_sel;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~dly_q;
  assign fall_o = ~sync_q & dly_q;

  // R3
  rise_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R3
  fall_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned DW     = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic [NUM_CH-1:0]            lvl_i,
  input  logic [NUM_CH-1:0]            rise_pulse_i,
  input  logic [NUM_CH-1:0]            fall_pulse_i,
  output logic [NUM_CH-1:0][SEL_W-1:0] sel_o,
  output logic [DW-1:0]                rdata_o,
  output logic [NUM_CH-1:0]            irq_o
);
  logic [NUM_CH-1:0][SEL_W-1:0] sel_q;
  logic [NUM_CH-1:0] mode_q, ena_q, enb_q, rise_q, fall_q;
  logic [NUM_CH-1:0] ena_d, enb_d, rise_d, fall_d, wb, edge_req, lvl_req;
  logic unused_wdata;

  assign wb = wdata_i[NUM_CH-1:0];
  assign unused_wdata = ^wdata_i[DW-1:NUM_CH];

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return we_i && (addr_i == a);
  endfunction

  always_comb begin
    ena_d = ena_q;
    if (hit(A_ENA_SET)) ena_d = ena_d | wb;
    if (hit(A_ENA_CLR)) ena_d = ena_d & ~wb;
    enb_d = enb_q;
    if (hit(A_ENB_SET)) enb_d = enb_d | wb;
    if (hit(A_ENB_CLR)) enb_d = enb_d & ~wb;

    rise_d = rise_q;
    fall_d = fall_q;
    if (hit(A_RISE))     rise_d = rise_d & ~wb;
    if (hit(A_FALL))     fall_d = fall_d & ~wb;
    if (hit(A_RISE_SET)) rise_d = rise_d | wb;
    if (hit(A_FALL_SET)) fall_d = fall_d | wb;
    if (hit(A_STAT)) begin
      rise_d = rise_d & ~(wb & ~mode_q);
      fall_d = fall_d & ~(wb & ~mode_q);
    end
    // a new edge outranks any clear in the same cycle
    rise_d = rise_d | rise_pulse_i;
    fall_d = fall_d | fall_pulse_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      mode_q <= '0;
      ena_q  <= '0;
      enb_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (hit(A_SEL0 + ADDR_W'(i))) sel_q[i] <= wdata_i[SEL_W-1:0];
      if (hit(A_MODE)) mode_q <= wb;
      ena_q  <= ena_d;
      enb_q  <= enb_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign edge_req = (rise_q & ena_q) | (fall_q & enb_q);
  assign lvl_req  = ena_q & ~(lvl_i ^ enb_q);
  assign irq_o    = (mode_q & lvl_req) | (~mode_q & edge_req);
  assign sel_o    = sel_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE: rdata_o[NUM_CH-1:0] = mode_q;
      A_ENA:  rdata_o[NUM_CH-1:0] = ena_q;
      A_ENB:  rdata_o[NUM_CH-1:0] = enb_q;
      A_RISE: rdata_o[NUM_CH-1:0] = rise_q;
      A_FALL: rdata_o[NUM_CH-1:0] = fall_q;
      A_STAT: rdata_o[NUM_CH-1:0] = irq_o;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == A_SEL0 + ADDR_W'(i)) rdata_o[SEL_W-1:0] = sel_q[i];
  end

  // R6
  edge_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_pulse_i) |=> ((rise_q & $past(rise_pulse_i)) == $past(rise_pulse_i)));
  // R7
  ena_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ENA_SET) |=> ((ena_q & $past(wb)) == $past(wb)));
  // R7
  ena_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ENA_CLR) |=> ((ena_q & $past(wb)) == '0));
  // R9
  lvl_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & mode_q & ~ena_q) == '0);
  // R10
  stat_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT && rise_pulse_i == '0)
      |=> ((rise_q & $past(wb & ~mode_q)) == '0));
endmodule

// File: rtl/pin_irq_engine.sv
module pin_irq_engine
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned DW       = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [NUM_CH-1:0]   irq_o
);
  localparam int unsigned SEL_W = $clog2(NUM_PINS);

  logic [NUM_CH-1:0][SEL_W-1:0] sel;
  logic [NUM_CH-1:0] lvl, rise, fall;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pirq_channel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) i_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pins_i(pins_i),
      .sel_i (sel[c]),
      .lvl_o (lvl[c]),
      .rise_o(rise[c]),
      .fall_o(fall[c])
    );
  end

  pirq_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .DW(DW)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .lvl_i       (lvl),
    .rise_pulse_i(rise),
    .fall_pulse_i(fall),
    .sel_o       (sel),
    .rdata_o     (rdata_o),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/test_pin_irq_engine.sv
module test_pin_irq_engine;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  int selm [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_engine i_pin_irq_engine (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, $sformatf("addr %h", a), rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_of(input int p);
    logic [7:0] m = '0;
    for (int j = 0; j < 8; j++) if (selm[j] == p) m[j] = 1'b1;
    return m;
  endfunction

  task automatic set_en(input logic [7:0] a, input logic [7:0] b);
    wr(5'h0B, 32'hFF); wr(5'h0A, {24'h0, a});
    wr(5'h0E, 32'hFF); wr(5'h0D, {24'h0, b});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] a, b, exp;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    for (int i = 0; i <= 8'h13; i++) rd("R1", 5'(i), 32'h0);
    chk("R1", "irq", {24'h0, irq}, 32'h0);

    // R2 select readback, R11 mode readback
    for (int k = 0; k < 8; k++) wr(5'(k), 32'((k * 5 + 3) % 32));
    for (int k = 0; k < 8; k++) rd("R2", 5'(k), 32'((k * 5 + 3) % 32));
    wr(5'h08, 32'hA5); rd("R11", 5'h08, 32'hA5);
    wr(5'h08, 32'h00);

    // R7 set/clear aliases
    wr(5'h0A, 32'h0F); wr(5'h0A, 32'h30); rd("R7", 5'h09, 32'h3F);
    wr(5'h0B, 32'h05); rd("R7", 5'h09, 32'h3A);
    wr(5'h0D, 32'hC0); wr(5'h0E, 32'h40); rd("R7", 5'h0C, 32'h80);
    rd("R7", 5'h0A, 32'h0); rd("R7", 5'h0B, 32'h0);
    rd("R7", 5'h0D, 32'h0); rd("R7", 5'h0E, 32'h0);
    set_en(8'h00, 8'h00);

    // R2 R3 R4 sweep of every channel over every pin
    for (int k = 0; k < 8; k++) begin wr(5'(k), 32'(k)); selm[k] = k; end
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 32; p++) begin
        wr(5'(k), 32'(p)); selm[k] = p;
        cyc(3);
        wr(5'h0F, 32'hFF); wr(5'h10, 32'hFF);
        pins[p] = 1'b1;
        cyc(2);
        rd("R3", 5'h0F, 32'h0);
        cyc(1);
        rd("R4", 5'h0F, {24'h0, mask_of(p)});
        rd("R4", 5'h10, 32'h0);
        pins[p] = 1'b0;
        cyc(3);
        rd("R4", 5'h10, {24'h0, mask_of(p)});
      end
      wr(5'(k), 32'(k)); selm[k] = k;
    end
    cyc(3);
    wr(5'h0F, 32'hFF); wr(5'h10, 32'hFF);

    // R5 partial clear and set
    pins[7:0] = 8'hFF; cyc(3);
    rd("R5", 5'h0F, 32'hFF);
    wr(5'h0F, 32'h0F); rd("R5", 5'h0F, 32'hF0);
    wr(5'h12, 32'h81); rd("R5", 5'h10, 32'h81);
    wr(5'h11, 32'h03); rd("R5", 5'h0F, 32'hF3);
    pins[7:0] = 8'h00; cyc(3);
    rd("R5", 5'h10, 32'hFF);
    wr(5'h0F, 32'hFF); wr(5'h10, 32'hFF);
    rd("R5", 5'h0F, 32'h0); rd("R5", 5'h10, 32'h0);

    // R6 clear in the capture cycle
    pins[0] = 1'b1; cyc(2);
    wr(5'h0F, 32'h01);
    rd("R6", 5'h0F, 32'h01);
    pins[0] = 1'b0; cyc(3);
    wr(5'h0F, 32'hFF); wr(5'h10, 32'hFF);

    // R8 edge requests over enable patterns
    wr(5'h11, 32'h3C); wr(5'h12, 32'h0F);
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        a = 8'(ai * 17); b = 8'(bi * 17) ^ 8'h96;
        set_en(a, b);
        exp = (8'h3C & a) | (8'h0F & b);
        chk("R8", "irq", {24'h0, irq}, {24'h0, exp});
        rd("R10", 5'h13, {24'h0, exp});
      end
    end

    // R10 status write clears edge channels only
    wr(5'h08, 32'hF0);
    wr(5'h13, 32'hFF);
    rd("R10", 5'h0F, 32'h30);
    rd("R10", 5'h10, 32'h00);
    wr(5'h0F, 32'hFF);

    // R3 level latency
    wr(5'h08, 32'hFF);
    set_en(8'hFF, 8'hFF);
    chk("R9", "irq idle", {24'h0, irq}, 32'h0);
    pins[7:0] = 8'hFF;
    cyc(1);
    chk("R3", "irq one edge", {24'h0, irq}, 32'h0);
    cyc(1);
    chk("R3", "irq two edges", {24'h0, irq}, 32'hFF);

    // R9 level requests over all pin patterns
    for (int e = 0; e < 4; e++) begin
      case (e)
        0: begin a = 8'hFF; b = 8'h00; end
        1: begin a = 8'hFF; b = 8'hFF; end
        2: begin a = 8'h5A; b = 8'hC3; end
        default: begin a = 8'h00; b = 8'hFF; end
      endcase
      set_en(a, b);
      for (int pv = 0; pv < 256; pv++) begin
        pins[7:0] = 8'(pv);
        cyc(2);
        exp = a & ~(8'(pv) ^ b);
        chk("R9", $sformatf("pins %h", pv), {24'h0, irq}, {24'h0, exp});
      end
    end
    // R10 status write leaves level channels untouched
    wr(5'h13, 32'hFF);
    chk("R10", "level after stat write", {24'h0, irq}, {24'h0, exp});

    finish_run();
  end
endmodule